// File: doc/BRIEF.md
# Biphase-Mark Audio Frame Transmitter

This block turns a stream of stereo audio sample pairs into one serial line in the biphase-mark code used by consumer digital audio links. For every frame it takes a left and a right sample, each with its own validity, user and channel-status bit. It builds two 32-slot subframes from them, adds a sync preamble and an even-parity bit to each, and groups the frames into blocks. The first subframe of each block carries a distinct preamble.

The block runs from one clock at the half-cell rate, which is 128 times the sample rate. Each clock cycle produces one half-cell on the line. `frameLatch` is high in the cycle before the edge that captures a new sample pair, so the data source knows when the next frame is taken. A two-bit word-length input sets how many of the 24 sample positions are significant. The unused low-order positions go out as zero.

Top module: `bmtx_top`

## Requirements
- R1: While `rst_n` is low, `lineOut` is 0 and `frameLatch` is 1. The first half-cell after reset starts the first subframe of a block.
- R2: `frameLatch` is high for exactly one cycle in every 128. The sample, flag and word-length inputs are captured on the rising edge that ends that cycle. Changes to those inputs at any other time have no effect on the frame being sent.
- R3: Each subframe starts with 8 preamble half-cells. Written earliest first and referred to a low line level before the subframe, the patterns are B = 11101000, M = 11100010 and W = 11100100. If the line was high before the subframe, the pattern is sent inverted.
- R4: The left subframe of frame 0 of each block uses B. Every other left subframe uses M, and every right subframe uses W. A block has `FRAMES_PER_BLOCK` frames.
- R5: Slots 4 to 27 carry the 24-bit sample, least significant bit first. Each slot is two half-cells, and slot s begins at half-cell 2s of its subframe.
- R6: `wordLen` encodes 0 = 16 bits, 1 = 18, 2 = 20 and 3 = 24 significant bits. The low 8, 6, 4 or 0 sample bits are sent as zero.
- R7: Slots 28, 29 and 30 carry that channel's validity, user and channel-status bit, in that order.
- R8: Slot 31 is set so that slots 4 to 31 hold an even number of ones.
- R9: In slots 4 to 31 the line toggles at the start of every cell. It toggles again mid-cell exactly when the bit is 1.
- R10: The line is low in the half-cell just before every subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock, 128 times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wordLen | input | 2 | Significant sample bits: 0=16, 1=18, 2=20, 3=24 |
| leftSample | input | 24 | Left-channel sample |
| rightSample | input | 24 | Right-channel sample |
| leftValid | input | 1 | Left validity bit |
| leftUser | input | 1 | Left user bit |
| leftStatus | input | 1 | Left channel-status bit |
| rightValid | input | 1 | Right validity bit |
| rightUser | input | 1 | Right user bit |
| rightStatus | input | 1 | Right channel-status bit |
| frameLatch | output | 1 | High in the cycle whose closing edge captures the inputs |
| lineOut | output | 1 | Biphase-mark serial line |

## Verification
The bench builds the block with `FRAMES_PER_BLOCK` set to 4 instead of 192. With that value the block wraps several times in about a dozen frames, so the return of the B preamble after the last M frame of a block can be observed within a short run. The bench decodes the line independently, cell by cell. Each preamble, sample field, flag and parity bit is checked for all four word lengths and for inputs that change in the middle of a frame.

// File: rtl/bmtx_pkg.sv
package bmtx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SLOTS    = 32;

  typedef enum logic [1:0] {
    WL16 = 2'd0,
    WL18 = 2'd1,
    WL20 = 2'd2,
    WL24 = 2'd3
  } wordLen_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       latch;
    logic       secondHalf;
    logic [4:0] slot;
    logic       rightSub;
    logic       blockHead;
  } bmCtl_t;

  // preamble half-cell levels, earliest in the MSB, for a low starting level
  localparam logic [7:0] PRE_B = 8'b11101000;
  localparam logic [7:0] PRE_M = 8'b11100010;
  localparam logic [7:0] PRE_W = 8'b11100100;
endpackage

// File: rtl/bmtx_ctrl.sv
module bmtx_ctrl
  import bmtx_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic   clk,
  input  logic   rst_n,
  output bmCtl_t ctl
);
  localparam int POS_W = $clog2(SLOTS * 4);
  localparam int FW    = (FRAMES_PER_BLOCK > 1) ? $clog2(FRAMES_PER_BLOCK) : 1;
  localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES_PER_BLOCK - 1);

  logic [POS_W-1:0] pos;
  logic [FW-1:0]    frameCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      frameCnt <= '0;
    end else begin
      pos <= pos + 1'b1;
      if (&pos) begin
        frameCnt <= (frameCnt == LAST_FRAME) ? '0 : frameCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.latch      = (pos == '0);
    ctl.secondHalf = pos[0];
    ctl.slot       = pos[5:1];
    ctl.rightSub   = pos[6];
    ctl.blockHead  = (frameCnt == '0) && !pos[6];
  end
endmodule

// File: rtl/bmtx_dp.sv
module bmtx_dp
  import bmtx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  bmCtl_t              ctl,
  input  wordLen_e            wordLen,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic [2:0]          leftFlags,   // {status, user, valid}
  input  logic [2:0]          rightFlags,
  output logic                lineOut
);
  logic [SAMPLE_W-1:0] leftQ, rightQ;
  logic [2:0]          leftFlagsQ, rightFlagsQ;
  logic                preBase;

  function automatic logic [SAMPLE_W-1:0] keepMask(wordLen_e wl);
    case (wl)
      WL16:    keepMask = {{16{1'b1}}, {(SAMPLE_W-16){1'b0}}};
      WL18:    keepMask = {{18{1'b1}}, {(SAMPLE_W-18){1'b0}}};
      WL20:    keepMask = {{20{1'b1}}, {(SAMPLE_W-20){1'b0}}};
      default: keepMask = '1;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leftQ       <= '0;
      rightQ      <= '0;
      leftFlagsQ  <= '0;
      rightFlagsQ <= '0;
    end else if (ctl.latch) begin
      leftQ       <= leftSample & keepMask(wordLen);
      rightQ      <= rightSample & keepMask(wordLen);
      leftFlagsQ  <= leftFlags;
      rightFlagsQ <= rightFlags;
    end
  end

  logic [SAMPLE_W-1:0] curSample;
  logic [2:0]          curFlags;
  logic                parityBit;
  logic [SLOTS-1:0]    slotBits;
  logic [7:0]          pattern;
  logic [2:0]          patIdx;
  logic                base;
  logic                nextLine;

  always_comb begin
    curSample = ctl.rightSub ? rightQ : leftQ;
    curFlags  = ctl.rightSub ? rightFlagsQ : leftFlagsQ;
    parityBit = ^{curFlags, curSample};
    slotBits  = {parityBit, curFlags, curSample, 4'b0000};
    if (ctl.blockHead)     pattern = PRE_B;
    else if (ctl.rightSub) pattern = PRE_W;
    else                   pattern = PRE_M;
    patIdx = 3'd7 - {ctl.slot[1:0], ctl.secondHalf};
    base   = (ctl.slot == 5'd0 && !ctl.secondHalf) ? lineOut : preBase;
    if (ctl.slot < 5'd4)    nextLine = pattern[patIdx] ^ base;
    else if (ctl.secondHalf) nextLine = lineOut ^ slotBits[ctl.slot];
    else                    nextLine = ~lineOut;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineOut <= 1'b0;
      preBase <= 1'b0;
    end else begin
      lineOut <= nextLine;
      if (ctl.slot == 5'd0 && !ctl.secondHalf) preBase <= lineOut;
    end
  end
endmodule

// File: rtl/bmtx_top.sv
module bmtx_top
  import bmtx_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  wordLen,
  input  logic [23:0] leftSample,
  input  logic [23:0] rightSample,
  input  logic        leftValid,
  input  logic        leftUser,
  input  logic        leftStatus,
  input  logic        rightValid,
  input  logic        rightUser,
  input  logic        rightStatus,
  output logic        frameLatch,
  output logic        lineOut
);
  bmCtl_t ctlBus;

  bmtx_ctrl #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctlBus)
  );

  bmtx_dp u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctlBus),
    .wordLen     (wordLen_e'(wordLen)),
    .leftSample  (leftSample),
    .rightSample (rightSample),
    .leftFlags   ({leftStatus, leftUser, leftValid}),
    .rightFlags  ({rightStatus, rightUser, rightValid}),
    .lineOut     (lineOut)
  );

  assign frameLatch = ctlBus.latch;
endmodule

// File: rtl/bmtx_checker.sv
module bmtx_checker
  import bmtx_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   lineOut,
  input logic   frameLatch,
  input bmCtl_t ctl
);
  p_latch_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frameLatch |=> !frameLatch);

  p_enter_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.slot == 5'd0 && !ctl.secondHalf) |=> lineOut != $past(lineOut));

  p_preamble_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.slot == 5'd1 && !ctl.secondHalf) |=> lineOut == $past(lineOut));

  p_head_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.blockHead |-> !ctl.rightSub);

  p_cell_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.slot >= 5'd4 && !ctl.secondHalf) |=> lineOut != $past(lineOut));

  p_start_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.slot == 5'd0 && !ctl.secondHalf) |-> !lineOut);
endmodule

bind bmtx_top bmtx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lineOut    (lineOut),
  .frameLatch (frameLatch),
  .ctl        (ctlBus)
);

// File: tb/test_bmtx_top.sv
`timescale 1ns/1ps
module test_bmtx_top;
  localparam int FPB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  wordLen = 2'd3;
  logic [23:0] leftSample = '0, rightSample = '0;
  logic        leftValid = 0, leftUser = 0, leftStatus = 0;
  logic        rightValid = 0, rightUser = 0, rightStatus = 0;
  logic        frameLatch, lineOut;

  int passCnt = 0;
  int failCnt = 0;
  int frameNo = 0;
  bit prevLevel = 1'b0;

  always #2 clk = ~clk;

  bmtx_top #(.FRAMES_PER_BLOCK(FPB)) i_bmtx_top (
    .clk(clk), .rst_n(rst_n), .wordLen(wordLen),
    .leftSample(leftSample), .rightSample(rightSample),
    .leftValid(leftValid), .leftUser(leftUser), .leftStatus(leftStatus),
    .rightValid(rightValid), .rightUser(rightUser), .rightStatus(rightStatus),
    .frameLatch(frameLatch), .lineOut(lineOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] expMask(input logic [1:0] wl);
    int keep;
    keep = (wl == 2'd0) ? 16 : (wl == 2'd1) ? 18 : (wl == 2'd2) ? 20 : 24;
    return ~((24'h1 << (24 - keep)) - 24'h1);
  endfunction

  task automatic checkSub(input logic [63:0] hs, input bit right,
                          input logic [23:0] smp, input logic [2:0] fl,
                          input logic [1:0] wl);
    logic [7:0]  expPat, actPat;
    logic [31:0] bits;
    bit head, edgesOk;
    head = (frameNo % FPB == 0) && !right;
    expPat = head ? 8'b11101000 : (right ? 8'b11100100 : 8'b11100010);
    expPat = expPat ^ {8{prevLevel}};
    for (int i = 0; i < 8; i++) actPat[7-i] = hs[i];
    check(prevLevel == 1'b0, "R10", "level before subframe", prevLevel, 0);
    check(actPat == expPat, (frameNo == 0 && !right) ? "R1,R3,R4" : "R3,R4",
          "preamble", actPat, expPat);
    bits = '0;
    edgesOk = 1'b1;
    for (int s = 4; s < 32; s++) begin
      if (hs[2*s] == hs[2*s-1]) edgesOk = 1'b0;
      bits[s] = hs[2*s] ^ hs[2*s+1];
    end
    check(edgesOk, "R9", "cell-start transitions", edgesOk, 1);
    check(bits[27:4] == (smp & expMask(wl)), "R5,R6", "sample field",
          bits[27:4], smp & expMask(wl));
    check(bits[30:28] == fl, "R7", "validity/user/status", bits[30:28], fl);
    check(^bits[31:4] == 1'b0, "R8", "even parity", ^bits[31:4], 0);
    prevLevel = hs[63];
  endtask

  task automatic runFrame(input logic [23:0] l, input logic [23:0] r,
                          input logic [2:0] fl, input logic [2:0] fr,
                          input logic [1:0] wl, input bit disturb);
    logic [127:0] h;
    int latches;
    check(frameLatch === 1'b1, "R2", "latch at frame start", frameLatch, 1);
    leftSample = l; rightSample = r; wordLen = wl;
    {leftStatus, leftUser, leftValid} = fl;
    {rightStatus, rightUser, rightValid} = fr;
    latches = 0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      h[i] = lineOut;
      if (frameLatch) latches++;
      if (disturb && i == 40) begin
        leftSample = ~l; rightSample = ~r; wordLen = ~wl;
        {leftStatus, leftUser, leftValid} = ~fl;
        {rightStatus, rightUser, rightValid} = ~fr;
      end
    end
    check(latches == 1, "R2", "one latch per 128 cycles", latches, 1);
    checkSub(h[63:0], 1'b0, l, fl, wl);
    checkSub(h[127:64], 1'b1, r, fr, wl);
    frameNo++;
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(lineOut === 1'b0, "R1", "line low in reset", lineOut, 0);
    check(frameLatch === 1'b1, "R1", "latch high in reset", frameLatch, 1);
    rst_n = 1'b1;
  endtask

  task automatic testFull24();
    runFrame(24'hA5C3F1, 24'h13579B, 3'b001, 3'b010, 2'd3, 1'b0);
    runFrame(24'h800001, 24'hFFFFFF, 3'b000, 3'b111, 2'd3, 1'b0);
  endtask

  task automatic testMasks();
    for (int w = 0; w < 3; w++)
      runFrame(24'hFFFFFF, 24'h5A5A5A, 3'b100, 3'b011, 2'(w), 1'b0);
  endtask

  task automatic testFlags();
    runFrame(24'h000000, 24'h000000, 3'b111, 3'b000, 2'd3, 1'b0);
    runFrame(24'h0F0F0F, 24'hF0F0F0, 3'b101, 3'b110, 2'd2, 1'b0);
  endtask

  task automatic testDisturb();
    runFrame(24'h3C3C3C, 24'hC3C3C3, 3'b010, 3'b101, 2'd1, 1'b1);
    runFrame(24'h123456, 24'h654321, 3'b001, 3'b100, 2'd0, 1'b1);
  endtask

  task automatic testBlockWrap();
    for (int k = 0; k < FPB + 1; k++)
      runFrame(24'(k * 24'h111111), 24'(~(k * 24'h020406)), 3'(k), 3'(7 - k),
               2'(k), 1'b0);
  endtask

  initial begin
    #(4 * 100000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testFull24();
    testMasks();
    testFlags();
    testDisturb();
    testBlockWrap();
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule